// File: doc/BRIEF.md
# Lamp Filament Current Regulator with Noise-Shaped DAC Drive

This block closes a feedback loop on the filament current of a calibration lamp. A converter delivers one 24-bit unsigned measurement per millisecond as a one-cycle strobe with data. On each strobe a PID stage compares the measurement with a programmable setpoint, using three signed fixed-point gains and an integrator with anti-windup clamping. It produces a 24-bit unsigned drive command, clipped to that range.

The DAC only accepts 16 bits, so a first-order noise shaper re-quantizes the command at the fast system clock. An 8-bit error register accumulates the eight bits below the DAC code on every cycle. Its carry bumps the upper 16 bits by one. Averaged over 256 cycles, the DAC code therefore carries the full 24-bit value. A mode input replaces the shaper with plain truncation. Dropping the enable input zeroes the DAC code and clears all loop and shaper state.

Top module: `lamp_pid_ds`

## Requirements
- R1: While `rst` is high, and after it is released with no sample, `dac_code` is 0.
- R2: For each sample, the command is computed as follows. The error e is `setpoint - smp_data`. The integrator is I' = clamp(I + e, ±INTEG_LIMIT). The command is (kp·e + ki·I' + kd·(e − e_prev)) arithmetically shifted right by 8. Gains are signed, with 8 fractional bits (256 = 1.0).
- R3: The integrator never leaves the range ±INTEG_LIMIT (default 2^20). Once it is pinned at the limit, an opposite error moves it away from the limit at once.
- R4: A negative command result yields 0. A result above 0xFFFFFF yields 0xFFFFFF.
- R5: A command is taken into the DAC path only on the cycle after its sample is processed. With `smp_vld` high at rising edge k, `dac_code` still shows the old value after edges k and k+1, and shows the new value after edge k+2. Between samples the command is held.
- R6: In shaped mode (`trunc_mode` = 0) with command C, where C[23:8] < 0xFFFF, the sum of any 256 consecutive `dac_code` values equals C.
- R7: In shaped mode, when C[23:8] = 0xFFFF, `dac_code` stays at 0xFFFF and never wraps.
- R8: With `trunc_mode` = 1, `dac_code` is constant and equals C[23:8].
- R9: One edge with `en` low sets `dac_code` to 0. It also clears the integrator, the previous error and the shaper's error register, so after re-enabling the first codes for C = 0x000080 are 0 and then 1.
- R10: A sample strobe that arrives while `en` is low, including in the very cycle `en` falls, is ignored. After re-enabling, `dac_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; low clears the state and zeroes the output |
| trunc_mode | input | 1 | 1 = plain truncation, 0 = noise-shaped drive |
| setpoint | input | 24 | Target measurement value, unsigned |
| gain_p | input | 16 | Proportional gain, signed, 8 fractional bits |
| gain_i | input | 16 | Integral gain, signed, 8 fractional bits |
| gain_d | input | 16 | Derivative gain, signed, 8 fractional bits |
| smp_vld | input | 1 | One-cycle strobe marking a new measurement |
| smp_data | input | 24 | Measurement value, unsigned |
| dac_code | output | 16 | Code sent to the DAC |

## Verification
Two events can land in the same clock cycle: a measurement strobe and the falling edge of the enable. The bench drives both at one falling clock edge. The outcome is judged from the output: the code must stay at zero after the loop is re-enabled, which shows that the clear won and the sample never reached the integrator or the command. The shaper's carry can also coincide with full scale. That case is judged by requiring every one of 256 consecutive codes to read 0xFFFF.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    localparam int SAMPLE_W    = 24;
    localparam int CODE_W      = 16;
    localparam int GAIN_W      = 16;
    localparam int GAIN_FRAC   = 8;
    localparam int INTEG_LIMIT = 1 << 20;

    typedef enum logic {
        DRV_SHAPED = 1'b0,
        DRV_TRUNC  = 1'b1
    } drive_mode_e;

endpackage

// File: rtl/lamp_pid_core.sv
module lamp_pid_core #(
    parameter int DW   = lamp_pkg::SAMPLE_W,
    parameter int GW   = lamp_pkg::GAIN_W,
    parameter int FRAC = lamp_pkg::GAIN_FRAC,
    parameter int LIM  = lamp_pkg::INTEG_LIMIT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [DW-1:0]        setpoint,
    input  logic signed [GW-1:0] kp,
    input  logic signed [GW-1:0] ki,
    input  logic signed [GW-1:0] kd,
    input  logic                 smp_vld,
    input  logic [DW-1:0]        smp_data,
    output logic [DW-1:0]        cmd,
    output logic                 cmd_vld
);
    localparam int EW  = DW + 1;
    localparam int DVW = DW + 2;
    localparam int SW  = GW + DVW + 2;
    localparam logic signed [EW:0] LIM_P = (EW+1)'(LIM);
    localparam logic signed [EW:0] LIM_N = -LIM_P;

    logic signed [EW-1:0]  err, integ, prev_err, integ_nx;
    logic signed [EW:0]    isum;
    logic signed [DVW-1:0] deriv;
    logic signed [SW-1:0]  p_term, i_term, d_term, acc, scaled;
    logic [DW-1:0]         sat_val;

    always_comb begin
        err   = $signed({1'b0, setpoint}) - $signed({1'b0, smp_data});
        isum  = $signed({integ[EW-1], integ}) + $signed({err[EW-1], err});
        if (isum > LIM_P)
            integ_nx = LIM_P[EW-1:0];
        else if (isum < LIM_N)
            integ_nx = LIM_N[EW-1:0];
        else
            integ_nx = isum[EW-1:0];
        deriv  = $signed({err[EW-1], err}) - $signed({prev_err[EW-1], prev_err});
        p_term = SW'(kp) * SW'(err);
        i_term = SW'(ki) * SW'(integ_nx);
        d_term = SW'(kd) * SW'(deriv);
        acc    = p_term + i_term + d_term;
        scaled = acc >>> FRAC;
        if (scaled[SW-1])
            sat_val = '0;
        else if (|scaled[SW-2:DW])
            sat_val = '1;
        else
            sat_val = scaled[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            integ    <= '0;
            prev_err <= '0;
            cmd      <= '0;
            cmd_vld  <= 1'b0;
        end else begin
            cmd_vld <= smp_vld;
            if (smp_vld) begin
                integ    <= integ_nx;
                prev_err <= err;
                cmd      <= sat_val;
            end
        end
    end

    AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (rst)
        ($signed({integ[EW-1], integ}) <= LIM_P) && ($signed({integ[EW-1], integ}) >= LIM_N))
        else $error("integrator outside clamp"); // R3

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && !smp_vld) |=> $stable(cmd))
        else $error("command moved without a sample"); // R5

    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cmd == '0 && !cmd_vld))
        else $error("sample accepted while disabled"); // R10

endmodule

// File: rtl/lamp_ds_requant.sv
module lamp_ds_requant
    import lamp_pkg::*;
#(
    parameter int DW = lamp_pkg::SAMPLE_W,
    parameter int CW = lamp_pkg::CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  drive_mode_e   mode,
    input  logic          load,
    input  logic [DW-1:0] cmd,
    output logic [CW-1:0] code
);
    localparam int FW = DW - CW;

    logic [DW-1:0] hold;
    logic [FW-1:0] err_acc;
    logic [FW:0]   lo_sum;
    logic [CW-1:0] hi, shaped;

    always_comb begin
        hi     = hold[DW-1:FW];
        lo_sum = {1'b0, err_acc} + {1'b0, hold[FW-1:0]};
        if (lo_sum[FW] && !(&hi))
            shaped = hi + CW'(1);
        else
            shaped = hi;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hold    <= '0;
            err_acc <= '0;
            code    <= '0;
        end else begin
            if (load)
                hold <= cmd;
            if (mode == DRV_TRUNC) begin
                code <= hi;
            end else begin
                err_acc <= lo_sum[FW-1:0];
                code    <= shaped;
            end
        end
    end

    AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (code == '0))
        else $error("code not zero after disable"); // R9

    AST_TRUNC_CODE: assert property (@(posedge clk) disable iff (rst)
        (en && mode == DRV_TRUNC) |=> (code == $past(hold[DW-1:FW])))
        else $error("truncated code mismatch"); // R8

    AST_SHAPE_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && mode == DRV_SHAPED) |=>
            (code == $past(hold[DW-1:FW])) || (code == $past(hold[DW-1:FW]) + CW'(1)))
        else $error("shaped code left its one-step window"); // R6

    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (en && mode == DRV_SHAPED && (&hold[DW-1:FW])) |=> (&code))
        else $error("code wrapped at full scale"); // R7

endmodule

// File: rtl/lamp_pid_ds.sv
module lamp_pid_ds
    import lamp_pkg::*;
#(
    parameter int DW   = lamp_pkg::SAMPLE_W,
    parameter int CW   = lamp_pkg::CODE_W,
    parameter int GW   = lamp_pkg::GAIN_W,
    parameter int FRAC = lamp_pkg::GAIN_FRAC,
    parameter int LIM  = lamp_pkg::INTEG_LIMIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trunc_mode,
    input  logic [DW-1:0] setpoint,
    input  logic [GW-1:0] gain_p,
    input  logic [GW-1:0] gain_i,
    input  logic [GW-1:0] gain_d,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    output logic [CW-1:0] dac_code
);
    logic [DW-1:0] pid_cmd;
    logic          pid_vld;
    drive_mode_e   mode;

    assign mode = trunc_mode ? DRV_TRUNC : DRV_SHAPED;

    lamp_pid_core #(
        .DW(DW), .GW(GW), .FRAC(FRAC), .LIM(LIM)
    ) pid_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .setpoint (setpoint),
        .kp       ($signed(gain_p)),
        .ki       ($signed(gain_i)),
        .kd       ($signed(gain_d)),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .cmd      (pid_cmd),
        .cmd_vld  (pid_vld)
    );

    lamp_ds_requant #(
        .DW(DW), .CW(CW)
    ) ds_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .mode (mode),
        .load (pid_vld),
        .cmd  (pid_cmd),
        .code (dac_code)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (dac_code == '0))
        else $error("code not zero in reset"); // R1

endmodule

// File: tb/lamp_pid_ds_tb_top.sv
module lamp_pid_ds_tb_top;
    localparam int CLK_PERIOD = 10;

    // {gain_p[15:0], sample[23:0], expected 256-cycle code sum[23:0]}
    localparam logic [63:0] VECS [0:5] = '{
        {16'd256, 24'h700000, 24'h100000},
        {16'd256, 24'h7FFF80, 24'h000080},
        {16'd256, 24'h7ABCDE, 24'h054322},
        {16'd256, 24'h900000, 24'h000000},
        {16'd512, 24'h000000, 24'hFFFF00},
        {16'd128, 24'h600000, 24'h100000}
    };

    logic        clk = 1'b0;
    logic        rst, en, trunc_mode, smp_vld;
    logic [23:0] setpoint, smp_data;
    logic [15:0] gain_p, gain_i, gain_d;
    logic [15:0] dac_code;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_pid_ds dut_i (
        .clk(clk), .rst(rst), .en(en), .trunc_mode(trunc_mode),
        .setpoint(setpoint), .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
        .smp_vld(smp_vld), .smp_data(smp_data), .dac_code(dac_code)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] d);
        smp_data = d;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic sum256(output longint s);
        s = 0;
        repeat (3) @(negedge clk);
        repeat (256) begin
            s += dac_code;
            @(negedge clk);
        end
    endtask

    task automatic reenable();
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint s;
        bit     all_ok;
        rst = 1'b1; en = 1'b1; trunc_mode = 1'b0; smp_vld = 1'b0;
        setpoint = 24'h800000; smp_data = '0;
        gain_p = 16'd256; gain_i = '0; gain_d = '0;
        repeat (3) @(negedge clk);
        chk("R1 code in reset", dac_code, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 code after reset", dac_code, 0);

        // R2 R4 R6: table walk, proportional only
        for (int i = 0; i < 6; i++) begin
            gain_p = VECS[i][63:48];
            send(VECS[i][47:24]);
            sum256(s);
            chk($sformatf("R2 R4 R6 vector %0d", i), s, longint'(VECS[i][23:0]));
        end

        // R7: full scale, no wrap
        gain_p = 16'd512;
        send(24'h000000);
        repeat (3) @(negedge clk);
        all_ok = 1'b1;
        repeat (256) begin
            if (dac_code != 16'hFFFF) all_ok = 1'b0;
            @(negedge clk);
        end
        chk("R7 code pinned at 0xFFFF", all_ok, 1);

        // R2: full PID with derivative and integral
        reenable();
        gain_p = 16'd128; gain_i = 16'd64; gain_d = 16'd256;
        send(24'h7F0000);
        sum256(s);
        chk("R2 pid first sample", s, 114688);
        send(24'h7E0000);
        sum256(s);
        chk("R2 pid second sample", s, 180224);

        // R3: integrator clamp
        reenable();
        gain_p = '0; gain_i = 16'd256; gain_d = '0;
        send(24'h740000); sum256(s); chk("R3 integ step 1", s, 786432);
        send(24'h740000); sum256(s); chk("R3 integ clamped", s, 1048576);
        send(24'h740000); sum256(s); chk("R3 integ held at limit", s, 1048576);
        send(24'h840000); sum256(s); chk("R3 integ leaves limit", s, 786432);

        // R9: disable zeroes code and clears integrator
        en = 1'b0;
        @(negedge clk);
        chk("R9 code zero after disable", dac_code, 0);
        en = 1'b1;
        @(negedge clk);
        send(24'h800000);
        sum256(s);
        chk("R9 integrator cleared", s, 0);

        // R9: shaper error register cleared
        reenable();
        gain_p = 16'd256; gain_i = '0;
        send(24'h7FFF80);
        @(negedge clk);
        @(negedge clk);
        chk("R9 first shaped code", dac_code, 0);
        @(negedge clk);
        chk("R9 second shaped code", dac_code, 1);

        // R10: sample in the very cycle enable falls
        reenable();
        gain_p = 16'd256;
        en = 1'b0; smp_data = 24'h000000; smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0; en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 same-cycle sample ignored", dac_code, 0);
        en = 1'b0;
        repeat (2) @(negedge clk);
        send(24'h000000);
        en = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 disabled sample ignored", dac_code, 0);

        // R5 R8: truncation mode and update timing
        trunc_mode = 1'b1;
        send(24'h700000);
        repeat (4) @(negedge clk);
        chk("R8 truncated code", dac_code, 16'h1000);
        send(24'h600000);
        chk("R5 old code after sample edge", dac_code, 16'h1000);
        @(negedge clk);
        chk("R5 old code one edge later", dac_code, 16'h1000);
        @(negedge clk);
        chk("R5 new code two edges later", dac_code, 16'h2000);
        send(24'h6FFF80);
        repeat (3) @(negedge clk);
        all_ok = 1'b1;
        repeat (8) begin
            if (dac_code != 16'h1000) all_ok = 1'b0;
            @(negedge clk);
        end
        chk("R8 low byte dropped and code steady", all_ok, 1);
        trunc_mode = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule